// File: doc/BRIEF.md
# Timebase Interval Timer

This block keeps a free-running binary counter that advances on every base clock cycle. It raises a periodic interval interrupt from one tapped bit of that counter. Software picks one of eight taps through a 16-bit control register. Each time the chosen tap falls from 1 to 0, a sticky flag is set. The interrupt request is the flag gated by an enable bit.

The counter cannot be loaded or stopped. Software can only zero it by writing a two-byte key to a separate byte-wide clear register. A one-cycle pulse reports every counter clear to a companion watchdog, whether the clear came from the key or from reset. A clear also wipes the edge history, so that a tap that was high before the clear does not produce a false interval event.

Top module: `tbase_timer`

## Requirements
- R1: While reset is asserted, `ctl_rdata` reads 0, `irq` is 0 and the counter is held at 0. With interval code 0, the first flag set after reset release lands exactly 8193 clock edges after release.
- R2: The counter advances by one on every clock edge, independently of the enable bit, the interval field and control writes. Interval events therefore repeat with a fixed period of 2^(T+1) cycles for tap bit T.
- R3: The interval code in control bits 13:11 selects a counter tap bit: code 0 through 7 select bits 12, 14, 16, 19, 21, 23, 25 and 26. The longest period is 2^27 cycles. The flag (bit 15) goes to 1 on the clock edge after the selected bit falls from 1 to 0. After a counter clear, this is clock edge 2^(T+1)+1.
- R4: Edge detection and flag setting run while the enable bit (bit 14) is 0, and `irq` stays 0 during that time.
- R5: `irq` is 1 exactly when both the flag (bit 15) and the enable (bit 14) read 1.
- R6: A control write with bit 15 = 0 clears the flag. A control write with bit 15 = 1 leaves the flag unchanged. A falling edge in the same cycle as a clearing write wins, and the flag reads 1.
- R7: A control write loads bit 14 and bits 13:11 on the next edge. Bits 10:0 always read 0 and ignore written data.
- R8: A clear-register write of A5h followed by a write of 5Ah zeroes the counter on the 5Ah write's edge. Any number of cycles may separate the two writes.
- R9: After A5h, a write of any byte other than 5Ah or A5h cancels the key. A later 5Ah then does not clear the counter unless A5h is written again first.
- R10: A 5Ah write with no preceding A5h has no effect on the counter.
- R11: `cnt_cleared` is 1 while reset is asserted and drops at the first edge after release. It is 1 for exactly the one cycle after each key clear.
- R12: A key clear also zeroes the edge history, so the clear never sets the flag by itself, even when the selected tap was 1 before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control register read value |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 8 | Clear register write byte |
| irq | output | 1 | Interval interrupt request |
| cnt_cleared | output | 1 | One-cycle counter-cleared pulse |

## Verification
The interval path is driven with code 0 and code 1 after a key clear taken at a known counter value. The code 1 run checks that nothing fires at the tap 12 time, which separates the tap mapping from a fixed period. A second code 0 event, raced against a clearing write, shows both the fixed period and the set-over-clear priority. Key sequences are tried as an immediate pair, a pair 700 cycles apart, a lone 5Ah, and A5h followed by a wrong byte and then 5Ah. In the last two cases the flag timing, still tied to the earlier clear, shows that the counter was not disturbed.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 1 << SEL_W;
    localparam int CTL_W    = 16;
    localparam int FLAG_BIT = 15;
    localparam int EN_BIT   = 14;
    localparam int SEL_LSB  = 11;

    localparam logic [7:0] KEY_ARM  = 8'hA5;
    localparam logic [7:0] KEY_FIRE = 8'h5A;

    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic             flag;
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    // counter bit observed for each interval code
    function automatic int tap_bit(input int code);
        case (code)
            0:       return 12;
            1:       return 14;
            2:       return 16;
            3:       return 19;
            4:       return 21;
            5:       return 23;
            6:       return 25;
            default: return 26;
        endcase
    endfunction

endpackage

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             cleared
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = clr ? '0 : st_q.cnt + 1'b1;
        st_d.pulse = clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.pulse <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign cleared = st_q.pulse;

endmodule

// File: rtl/tbt_key_fsm.sv
module tbt_key_fsm
    import tbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       fire
);

    typedef struct packed {
        key_state_e st;
    } key_reg_t;

    key_reg_t kr_d, kr_q;

    always_comb begin
        kr_d = kr_q;
        fire = 1'b0;
        if (wr) begin
            unique case (kr_q.st)
                KEY_IDLE: begin
                    if (wdata == KEY_ARM) kr_d.st = KEY_ARMED;
                end
                KEY_ARMED: begin
                    if (wdata == KEY_FIRE) begin
                        fire    = 1'b1;
                        kr_d.st = KEY_IDLE;
                    end else if (wdata != KEY_ARM) begin
                        kr_d.st = KEY_IDLE;
                    end
                end
                default: kr_d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kr_q.st <= KEY_IDLE;
        end else begin
            kr_q <= kr_d;
        end
    end

endmodule

// File: rtl/tbt_tap_flag.sv
module tbt_tap_flag
    import tbt_pkg::*;
#(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_clr,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             irq
);

    typedef struct packed {
        ctl_t ctl;
        logic prev;
    } tf_state_t;

    tf_state_t st_d, st_q;

    logic [NUM_TAPS-1:0] tap_vec;
    logic                tap_now;
    logic                fall;
    logic                unused_bits;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int BIT = tap_bit(g);
        if (BIT < CNT_W) begin : g_real
            assign tap_vec[g] = cnt[BIT];
        end else begin : g_none
            assign tap_vec[g] = 1'b0;
        end
    end

    assign unused_bits = ^{ctl_wdata[SEL_LSB-1:0], cnt};

    always_comb begin
        tap_now   = tap_vec[st_q.ctl.sel];
        fall      = st_q.prev & ~tap_now;
        st_d      = st_q;
        st_d.prev = cnt_clr ? 1'b0 : tap_now;
        if (ctl_wr) begin
            st_d.ctl.en  = ctl_wdata[EN_BIT];
            st_d.ctl.sel = ctl_wdata[SEL_LSB +: SEL_W];
            if (!ctl_wdata[FLAG_BIT]) st_d.ctl.flag = 1'b0;
        end
        if (fall) st_d.ctl.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctl_rdata                        = '0;
        ctl_rdata[FLAG_BIT]              = st_q.ctl.flag;
        ctl_rdata[EN_BIT]                = st_q.ctl.en;
        ctl_rdata[SEL_LSB +: SEL_W]      = st_q.ctl.sel;
        irq                              = st_q.ctl.flag & st_q.ctl.en;
    end

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W = 27
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    output logic [15:0] ctl_rdata,
    input  logic        clr_wr,
    input  logic [7:0]  clr_wdata,
    output logic        irq,
    output logic        cnt_cleared
);

    logic [CNT_W-1:0] cnt;
    logic             key_fire;

    tbt_key_fsm u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (clr_wr),
        .wdata (clr_wdata),
        .fire  (key_fire)
    );

    tbt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (key_fire),
        .cnt     (cnt),
        .cleared (cnt_cleared)
    );

    tbt_tap_flag #(.CNT_W(CNT_W)) u_tap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .cnt_clr   (key_fire),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .irq       (irq)
    );

endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk
    import tbt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_wr,
    input logic [15:0] ctl_wdata,
    input logic [15:0] ctl_rdata,
    input logic        clr_wr,
    input logic [7:0]  clr_wdata,
    input logic        irq,
    input logic        cnt_cleared
);

    logic unused_irq;
    assign unused_irq = irq;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_cleared |=> !cnt_cleared); // R11

    AST_PULSE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cleared && $past(rst_n)) |-> $past(clr_wr && clr_wdata == KEY_FIRE)); // R8

    AST_CTL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata[EN_BIT] == $past(ctl_wdata[EN_BIT])) &&
                   (ctl_rdata[SEL_LSB +: SEL_W] == $past(ctl_wdata[SEL_LSB +: SEL_W]))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[FLAG_BIT] && !(ctl_wr && !ctl_wdata[FLAG_BIT])) |=> ctl_rdata[FLAG_BIT]); // R6

    AST_NO_FLAG_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[FLAG_BIT]) |-> !$past(cnt_cleared)); // R12

endmodule

bind tbase_timer tbase_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .clr_wr      (clr_wr),
    .clr_wdata   (clr_wdata),
    .irq         (irq),
    .cnt_cleared (cnt_cleared)
);

// File: tb/sim_tbase_timer.sv
`timescale 1ns/1ps
module sim_tbase_timer;

    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_wdata = '0;
    logic        irq;
    logic        cnt_cleared;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int e0 = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tbase_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ctl_rdata   (ctl_rdata),
        .clr_wr      (clr_wr),
        .clr_wdata   (clr_wdata),
        .irq         (irq),
        .cnt_cleared (cnt_cleared)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic ctl_write(input logic [15:0] v);
        ctl_wr    = 1'b1;
        ctl_wdata = v;
        @(posedge clk);
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic key_write(input logic [7:0] b);
        clr_wr    = 1'b1;
        clr_wdata = b;
        @(posedge clk);
        @(negedge clk);
        clr_wr    = 1'b0;
    endtask

    task automatic t_reset_and_regs();
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", ctl_rdata, 16'h0000);
        chk("R1 irq in reset", irq, 1'b0);
        chk("R11 pulse in reset", cnt_cleared, 1'b1);
        rst_n = 1'b1;
        e0 = cyc;
        @(negedge clk);
        chk("R11 pulse drops after release", cnt_cleared, 1'b0);
        ctl_write(16'hFFFF);
        chk("R7 readback all-ones write", ctl_rdata, 16'h7800);
        chk("R7 irq with flag clear", irq, 1'b0);
        ctl_write(16'h07FF);
        chk("R7 low bits ignored", ctl_rdata, 16'h0000);
        wait_until(e0 + 8192);
        chk("R1 no flag before first period", ctl_rdata[15], 1'b0);
        @(negedge clk);
        chk("R1 flag at 8193 after release", ctl_rdata[15], 1'b1);
        chk("R4 irq masked with enable 0", irq, 1'b0);
        ctl_write(16'hC000);
        chk("R6 write-1 keeps flag", ctl_rdata, 16'hC000);
        chk("R5 irq when flag and enable", irq, 1'b1);
        ctl_write(16'h4000);
        chk("R6 write-0 clears flag", ctl_rdata, 16'h4000);
        chk("R5 irq drops with flag", irq, 1'b0);
    endtask

    task automatic t_code0_period();
        wait_until(e0 + 12500);
        key_write(8'hA5);
        chk("R8 no pulse on A5", cnt_cleared, 1'b0);
        key_write(8'h5A);
        chk("R8 pulse on key clear", cnt_cleared, 1'b1);
        e0 = cyc;
        @(negedge clk);
        chk("R11 pulse one cycle", cnt_cleared, 1'b0);
        chk("R12 clear sets no flag", ctl_rdata[15], 1'b0);
        wait_until(e0 + 8192);
        chk("R3 code0 irq not yet", irq, 1'b0);
        @(negedge clk);
        chk("R3 code0 flag at 8193", ctl_rdata[15], 1'b1);
        chk("R5 code0 irq", irq, 1'b1);
        ctl_write(16'h4000);
        chk("R6 flag cleared", ctl_rdata[15], 1'b0);
        wait_until(e0 + 16384);
        chk("R2 no flag before second period", ctl_rdata[15], 1'b0);
        ctl_write(16'h4000);
        chk("R6 set wins over clearing write", ctl_rdata[15], 1'b1);
        chk("R2 second period at 16385", irq, 1'b1);
    endtask

    task automatic t_code1();
        key_write(8'hA5);
        key_write(8'h5A);
        chk("R8 pulse code1 clear", cnt_cleared, 1'b1);
        e0 = cyc;
        ctl_write(16'h4800);
        chk("R7 code1 readback", ctl_rdata, 16'h4800);
        wait_until(e0 + 16385);
        chk("R3 code1 ignores bit 12", ctl_rdata[15], 1'b0);
        wait_until(e0 + 32768);
        chk("R3 code1 no flag before 32769", ctl_rdata[15], 1'b0);
        @(negedge clk);
        chk("R3 code1 flag at 32769", ctl_rdata[15], 1'b1);
        chk("R5 code1 irq", irq, 1'b1);
    endtask

    task automatic t_key_orders();
        ctl_write(16'h4000);
        chk("R6 flag cleared before key tests", ctl_rdata[15], 1'b0);
        key_write(8'hA5);
        repeat (700) @(negedge clk);
        key_write(8'h5A);
        chk("R8 clear after long gap", cnt_cleared, 1'b1);
        e0 = cyc;
        wait_until(e0 + 100);
        key_write(8'h5A);
        chk("R10 lone 5A no pulse", cnt_cleared, 1'b0);
        key_write(8'hA5);
        key_write(8'h33);
        chk("R9 wrong byte no pulse", cnt_cleared, 1'b0);
        key_write(8'h5A);
        chk("R9 5A after cancel no pulse", cnt_cleared, 1'b0);
        wait_until(e0 + 8192);
        chk("R9 R10 no flag before 8193", ctl_rdata[15], 1'b0);
        @(negedge clk);
        chk("R9 R10 counter undisturbed", ctl_rdata[15], 1'b1);
    endtask

    always @(negedge clk) begin
        if (cyc >= LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_and_regs();
        t_code0_period();
        t_code1();
        t_key_orders();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule